// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Sequencer

This block is the architectural register store of a 32-bit core that runs in one of seven privilege modes. Sixteen register indices are visible at any time. Which physical register stands behind an index depends on the current mode. The block also holds the current status word and one saved status word for each of the five exception modes. It carries out the exception entry and exception return sequences as single-cycle atomic steps.

Decode and the datapath drive the block through plain strobes rather than valid/ready channels. Every request is accepted in the cycle it is presented, so there is no back-pressure path. Index 15 is the program counter, which lives outside the file. The block reports a new PC value with a one-cycle `pc_load` pulse and `pc_next`. A high-vectors input moves the vector table to a fixed upper base. Arbitration between simultaneous exception sources is done upstream: the block sees one request with its kind.

Top module: `banked_regfile_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, the status word is 0x000000D3 (Supervisor mode with I and F set, T clear, flags clear). Every register reads 0 and `pc_load` is 0.
- R2: Indices 0-7 name the same registers in all modes. Indices 8-12 name one set in FIQ mode and another set shared by all other modes. Indices 13 and 14 are private to each of FIQ, IRQ, Supervisor, Abort and Undefined. User and System share one bank.
- R3: Both read ports are combinational from the current mode. A write with `wr_en` becomes readable after the next rising edge. Index 15 always reads 0, and writes to index 15 are ignored.
- R4: The mode is the status field in bits 4:0. The encodings are: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011, System 11111.
- R5: On `exc_req`, the saved status of the target mode takes the old status. In the new status, bit 5 (T) is cleared, bit 7 (I) is set, and the mode field becomes the target mode. Bit 6 (F) is set for kinds 0 and 7 and is otherwise unchanged. Bits 31:8 are unchanged.
- R6: The target mode for each `exc_kind` value is: 0 reset, 2 software interrupt and 5 reserved go to Supervisor; 1 undefined goes to Undefined; 3 prefetch abort and 4 data abort go to Abort; 6 goes to IRQ; 7 goes to FIQ. The target mode's index 14 takes `exc_ret_addr`. One cycle later `pc_load` is 1 and `pc_next` equals 4 × kind.
- R7: With `hivec_en` high at the request, `pc_next` is 0xFFFF0000 + 4 × kind.
- R8: On `exc_return` in an exception mode, the status is restored from that mode's saved status. One cycle later `pc_load` is 1 and `pc_next` holds that mode's index 14.
- R9: On `exc_return` in User or System mode, the status is unchanged. `pc_next` still takes the current bank's index 14.
- R10: `sr_wr_en` writes status byte k (bits 8k+7:8k) from `sr_wr_data` when `sr_wr_mask[k]` is set, in any mode other than User.
- R11: In User mode, only mask bit 3 (bits 31:24) takes effect. Other bytes are ignored.
- R12: `exc_req` takes precedence over `exc_return`. Either one cancels `wr_en` and `sr_wr_en` in the same cycle. `pc_load` is only ever 1 in the cycle after one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hivec_en | input | 1 | Place the vector table at the upper base |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_mask | input | 4 | Byte-lane mask for the status write |
| sr_wr_data | input | 32 | Status write data |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception kind (vector slot) |
| exc_ret_addr | input | 32 | Return address stored on entry |
| exc_return | input | 1 | Exception return strobe |
| cur_status | output | 32 | Current status word |
| cur_mode | output | 5 | Current mode field |
| pc_load | output | 1 | New PC valid this cycle |
| pc_next | output | 32 | New PC value |

## Verification
The hardest case to reach is an entry that must leave F clear while also clearing a T bit that was set. Reset leaves T clear and F set, so the stimulus first writes the control byte to 0x33 from Supervisor mode. Every table entry then starts from that same status, because each entry is followed by a return that must restore it, which also exercises every saved status register. A cycle that raises entry, return, a register write and a status write all at once from User mode checks precedence, and is only reachable after the status write has demoted the core.

// File: rtl/bkr_pkg.sv
package bkr_pkg;
  localparam int IDX_W     = 4;
  localparam int ARCH_REGS = 1 << IDX_W;
  localparam int SHARED_LO = 8;
  localparam int FIQ_HI_N  = 5;
  localparam int NUM_BANKS = 6;
  localparam int PRIV_PAIR = 2;
  localparam int NUM_PHYS  = SHARED_LO + 2 * FIQ_HI_N + NUM_BANKS * PRIV_PAIR;
  localparam int PHYS_W    = $clog2(NUM_PHYS);
  localparam int KIND_W    = 3;
  localparam int MODE_W    = 5;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: bank_of = BK_FIQ;
      MODE_IRQ: bank_of = BK_IRQ;
      MODE_SVC: bank_of = BK_SVC;
      MODE_ABT: bank_of = BK_ABT;
      MODE_UND: bank_of = BK_UND;
      default:  bank_of = BK_USR;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(input bank_e b, input logic [IDX_W-1:0] idx);
    int r;
    r = int'(idx);
    if (r < SHARED_LO)
      phys_of = PHYS_W'(r);
    else if (r < SHARED_LO + FIQ_HI_N)
      phys_of = (b == BK_FIQ) ? PHYS_W'(r + FIQ_HI_N) : PHYS_W'(r);
    else
      phys_of = PHYS_W'(SHARED_LO + 2 * FIQ_HI_N + PRIV_PAIR * int'(b) + (r - SHARED_LO - FIQ_HI_N));
  endfunction
endpackage

// File: rtl/bkr_bank_map.sv
module bkr_bank_map
  import bkr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys,
  output logic              hit
);
  bank_e bank;

  always_comb begin
    bank = bank_of(mode);
    phys = phys_of(bank, idx);
    hit  = (idx != IDX_W'(ARCH_REGS - 1));
  end
endmodule

// File: rtl/bkr_vector_unit.sv
module bkr_vector_unit
  import bkr_pkg::*;
#(
  parameter int                 DATA_W     = 32,
  parameter logic [DATA_W-1:0]  HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic [KIND_W-1:0] kind,
  input  logic              hivec_en,
  output logic [MODE_W-1:0] tgt_mode,
  output logic              tgt_set_f,
  output logic [DATA_W-1:0] vec_addr
);
  logic [DATA_W-1:0] base;

  always_comb begin
    case (kind)
      3'd1:       tgt_mode = MODE_UND;
      3'd3, 3'd4: tgt_mode = MODE_ABT;
      3'd6:       tgt_mode = MODE_IRQ;
      3'd7:       tgt_mode = MODE_FIQ;
      default:    tgt_mode = MODE_SVC;
    endcase
    tgt_set_f = (kind == 3'd0) || (kind == 3'd7);
    base      = hivec_en ? HIVEC_BASE : '0;
    vec_addr  = base + {{(DATA_W-KIND_W-2){1'b0}}, kind, 2'b00};
  end
endmodule

// File: rtl/bkr_status_unit.sv
module bkr_status_unit
  import bkr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enter,
  input  logic [MODE_W-1:0]    tgt_mode,
  input  logic                 tgt_set_f,
  input  logic                 leave,
  input  logic                 sr_take,
  input  logic [DATA_W/8-1:0]  sr_mask,
  input  logic [DATA_W-1:0]    sr_data,
  output logic [DATA_W-1:0]    status
);
  localparam int STRB_W = DATA_W / 8;
  localparam logic [DATA_W-1:0] RESET_SR =
    DATA_W'((1 << BIT_I) | (1 << BIT_F)) | DATA_W'(MODE_SVC);

  logic [DATA_W-1:0] saved [NUM_BANKS];
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] entered;
  bank_e             cur_bank;
  bank_e             tgt_bank;
  logic              user_mode;
  logic              has_saved;

  always_comb begin
    cur_bank  = bank_of(status[MODE_W-1:0]);
    tgt_bank  = bank_of(tgt_mode);
    user_mode = (status[MODE_W-1:0] == MODE_USR);
    has_saved = (cur_bank != BK_USR);

    entered                 = status;
    entered[BIT_I]          = 1'b1;
    entered[BIT_F]          = status[BIT_F] | tgt_set_f;
    entered[BIT_T]          = 1'b0;
    entered[MODE_W-1:0]     = tgt_mode;

    merged = status;
    for (int k = 0; k < STRB_W; k++) begin
      if (sr_mask[k] && (!user_mode || k == STRB_W - 1))
        merged[8*k +: 8] = sr_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= RESET_SR;
      for (int b = 0; b < NUM_BANKS; b++) saved[b] <= '0;
    end else if (enter) begin
      saved[int'(tgt_bank)] <= status;
      status                <= entered;
    end else if (leave) begin
      if (has_saved) status <= saved[int'(cur_bank)];
    end else if (sr_take) begin
      status <= merged;
    end
  end
endmodule

// File: rtl/banked_regfile_core.sv
module banked_regfile_core
  import bkr_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hivec_en,
  input  logic [IDX_W-1:0]     rd_a_idx,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [IDX_W-1:0]     rd_b_idx,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 sr_wr_en,
  input  logic [DATA_W/8-1:0]  sr_wr_mask,
  input  logic [DATA_W-1:0]    sr_wr_data,
  input  logic                 exc_req,
  input  logic [KIND_W-1:0]    exc_kind,
  input  logic [DATA_W-1:0]    exc_ret_addr,
  input  logic                 exc_return,
  output logic [DATA_W-1:0]    cur_status,
  output logic [MODE_W-1:0]    cur_mode,
  output logic                 pc_load,
  output logic [DATA_W-1:0]    pc_next
);
  localparam int LK_N    = 5;
  localparam int LK_RDA  = 0;
  localparam int LK_RDB  = 1;
  localparam int LK_WR   = 2;
  localparam int LK_ENT  = 3;
  localparam int LK_RET  = 4;
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(14);

  logic                 enter_go, leave_go, sr_go, rf_go;
  logic [MODE_W-1:0]    tgt_mode;
  logic                 tgt_set_f;
  logic [DATA_W-1:0]    vec_addr;

  logic [MODE_W-1:0]    lk_mode [LK_N];
  logic [IDX_W-1:0]     lk_idx  [LK_N];
  logic [PHYS_W-1:0]    lk_phys [LK_N];
  logic                 lk_hit  [LK_N];

  logic [DATA_W-1:0]    rf [NUM_PHYS];

  always_comb begin
    enter_go = exc_req;
    leave_go = exc_return && !exc_req;
    sr_go    = sr_wr_en && !exc_req && !exc_return;
    rf_go    = wr_en && !exc_req && !exc_return;
  end

  bkr_vector_unit #(.DATA_W(DATA_W), .HIVEC_BASE(HIVEC_BASE)) u_vec (
    .kind      (exc_kind),
    .hivec_en  (hivec_en),
    .tgt_mode  (tgt_mode),
    .tgt_set_f (tgt_set_f),
    .vec_addr  (vec_addr)
  );

  bkr_status_unit #(.DATA_W(DATA_W)) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (enter_go),
    .tgt_mode  (tgt_mode),
    .tgt_set_f (tgt_set_f),
    .leave     (leave_go),
    .sr_take   (sr_go),
    .sr_mask   (sr_wr_mask),
    .sr_data   (sr_wr_data),
    .status    (cur_status)
  );

  assign cur_mode = cur_status[MODE_W-1:0];

  always_comb begin
    lk_mode[LK_RDA] = cur_mode;  lk_idx[LK_RDA] = rd_a_idx;
    lk_mode[LK_RDB] = cur_mode;  lk_idx[LK_RDB] = rd_b_idx;
    lk_mode[LK_WR]  = cur_mode;  lk_idx[LK_WR]  = wr_idx;
    lk_mode[LK_ENT] = tgt_mode;  lk_idx[LK_ENT] = LINK_IDX;
    lk_mode[LK_RET] = cur_mode;  lk_idx[LK_RET] = LINK_IDX;
  end

  for (genvar g = 0; g < LK_N; g++) begin : g_lookup
    bkr_bank_map u_map (
      .mode (lk_mode[g]),
      .idx  (lk_idx[g]),
      .phys (lk_phys[g]),
      .hit  (lk_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PHYS; p++) rf[p] <= '0;
    end else if (enter_go) begin
      rf[lk_phys[LK_ENT]] <= exc_ret_addr;
    end else if (rf_go && lk_hit[LK_WR]) begin
      rf[lk_phys[LK_WR]] <= wr_data;
    end
  end

  always_comb begin
    rd_a_data = lk_hit[LK_RDA] ? rf[lk_phys[LK_RDA]] : '0;
    rd_b_data = lk_hit[LK_RDB] ? rf[lk_phys[LK_RDB]] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load <= 1'b0;
      pc_next <= '0;
    end else if (enter_go) begin
      pc_load <= 1'b1;
      pc_next <= vec_addr;
    end else if (leave_go) begin
      pc_load <= 1'b1;
      pc_next <= rf[lk_phys[LK_RET]];
    end else begin
      pc_load <= 1'b0;
    end
  end
endmodule

// File: rtl/bkr_checker.sv
module bkr_checker
  import bkr_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hivec_en,
  input logic                sr_wr_en,
  input logic                exc_req,
  input logic [KIND_W-1:0]   exc_kind,
  input logic                exc_return,
  input logic [DATA_W-1:0]   cur_status,
  input logic [MODE_W-1:0]   cur_mode,
  input logic                pc_load,
  input logic [DATA_W-1:0]   pc_next
);
  function automatic logic [MODE_W-1:0] want_mode(input logic [KIND_W-1:0] k);
    case (k)
      3'd0, 3'd2, 3'd5: want_mode = 5'b10011;
      3'd1:             want_mode = 5'b11011;
      3'd3, 3'd4:       want_mode = 5'b10111;
      3'd6:             want_mode = 5'b10010;
      default:          want_mode = 5'b10001;
    endcase
  endfunction

  p_entry_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> cur_mode == want_mode($past(exc_kind)));

  p_entry_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> cur_status[BIT_I] && !cur_status[BIT_T] &&
                (cur_status[DATA_W-1:8] == $past(cur_status[DATA_W-1:8])));

  p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> pc_load &&
      pc_next == (($past(hivec_en) ? HIVEC_BASE : '0) + DATA_W'({$past(exc_kind), 2'b00})));

  p_user_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 5'b10000 && sr_wr_en && !exc_req && !exc_return)
      |=> cur_status[23:0] == $past(cur_status[23:0]));

  p_ret_nosave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_req && (cur_mode == 5'b10000 || cur_mode == 5'b11111))
      |=> $stable(cur_status));

  p_load_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(exc_req || exc_return));
endmodule

bind banked_regfile_core bkr_checker #(.DATA_W(DATA_W), .HIVEC_BASE(HIVEC_BASE)) u_bkr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hivec_en   (hivec_en),
  .sr_wr_en   (sr_wr_en),
  .exc_req    (exc_req),
  .exc_kind   (exc_kind),
  .exc_return (exc_return),
  .cur_status (cur_status),
  .cur_mode   (cur_mode),
  .pc_load    (pc_load),
  .pc_next    (pc_next)
);

// File: tb/test_banked_regfile_core.sv
module test_banked_regfile_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hivec_en;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, sr_wr_en;
  logic [3:0]  sr_wr_mask;
  logic [31:0] sr_wr_data;
  logic        exc_req, exc_return;
  logic [2:0]  exc_kind;
  logic [31:0] exc_ret_addr;
  logic [31:0] cur_status;
  logic [4:0]  cur_mode;
  logic        pc_load;
  logic [31:0] pc_next;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  banked_regfile_core i_banked_regfile_core (
    .clk, .rst_n, .hivec_en,
    .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
    .wr_en, .wr_idx, .wr_data,
    .sr_wr_en, .sr_wr_mask, .sr_wr_data,
    .exc_req, .exc_kind, .exc_ret_addr, .exc_return,
    .cur_status, .cur_mode, .pc_load, .pc_next
  );

  // {kind[2:0], hivec, expected mode[4:0]}
  localparam logic [8:0] VEC [10] = '{
    {3'd1, 1'b0, 5'b11011},
    {3'd2, 1'b0, 5'b10011},
    {3'd3, 1'b0, 5'b10111},
    {3'd4, 1'b0, 5'b10111},
    {3'd5, 1'b0, 5'b10011},
    {3'd6, 1'b0, 5'b10010},
    {3'd7, 1'b0, 5'b10001},
    {3'd0, 1'b0, 5'b10011},
    {3'd6, 1'b1, 5'b10010},
    {3'd4, 1'b1, 5'b10111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wreg(input logic [3:0] i, input logic [31:0] v);
    wr_en = 1'b1; wr_idx = i; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic srw(input logic [3:0] m, input logic [31:0] v);
    sr_wr_en = 1'b1; sr_wr_mask = m; sr_wr_data = v;
    tick();
    sr_wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] i, output logic [31:0] v);
    rd_a_idx = i;
    #1;
    v = rd_a_data;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, pre, exp_sr, exp_pc, ra;
    logic [2:0]  k;
    logic        hv;
    logic [4:0]  m;
    logic        f;

    rst_n = 1'b0; hivec_en = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; wr_en = 1'b0;
    sr_wr_en = 1'b0; sr_wr_mask = '0; sr_wr_data = '0;
    exc_req = 1'b0; exc_return = 1'b0; exc_kind = '0; exc_ret_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 status", cur_status, 32'h0000_00D3);
    chk("R1 mode", {27'd0, cur_mode}, 32'h13);
    chk("R1 pc_load", {31'd0, pc_load}, 32'd0);
    rreg(4'd14, v); chk("R1 r14 zero", v, 32'd0);

    // R2 banking across SVC / SYS / FIQ
    wreg(4'd0, 32'h1111_0000);
    wreg(4'd8, 32'h8080_8080);
    wreg(4'd13, 32'h0000_0A13);
    wreg(4'd14, 32'h0000_0A14);
    srw(4'b0001, 32'h0000_00DF);
    chk("R4 system mode", {27'd0, cur_mode}, 32'h1F);
    rreg(4'd0, v);  chk("R2 r0 shared in SYS", v, 32'h1111_0000);
    rreg(4'd8, v);  chk("R2 r8 shared SVC/SYS", v, 32'h8080_8080);
    rreg(4'd13, v); chk("R2 r13 private to SVC", v, 32'd0);
    wreg(4'd13, 32'h0000_5513);
    srw(4'b0001, 32'h0000_00D1);
    chk("R4 fiq mode", {27'd0, cur_mode}, 32'h11);
    rreg(4'd8, v);  chk("R2 r8 private in FIQ", v, 32'd0);
    wreg(4'd8, 32'h0000_F8F8);
    rreg(4'd0, v);  chk("R2 r0 shared in FIQ", v, 32'h1111_0000);
    rreg(4'd13, v); chk("R2 r13 private in FIQ", v, 32'd0);
    srw(4'b0001, 32'h0000_00D3);
    rreg(4'd8, v);  chk("R2 r8 untouched by FIQ write", v, 32'h8080_8080);
    rreg(4'd13, v); chk("R2 SVC r13 kept", v, 32'h0000_0A13);
    rd_b_idx = 4'd14; #1;
    chk("R3 port B SVC r14", rd_b_data, 32'h0000_0A14);

    // R3 write timing and index 15
    wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h0000_0077;
    rreg(4'd1, v); chk("R3 write not visible before edge", v, 32'd0);
    tick(); wr_en = 1'b0;
    rreg(4'd1, v); chk("R3 write visible after edge", v, 32'h0000_0077);
    wreg(4'd15, 32'hDEAD_BEEF);
    rreg(4'd15, v); chk("R3 index 15 reads zero", v, 32'd0);

    // R10 byte-lane status writes in a privileged mode
    srw(4'b1000, 32'hA800_0000);
    chk("R10 flag byte", cur_status, 32'hA800_00D3);
    srw(4'b0001, 32'h0000_0033);
    chk("R10 control byte", cur_status, 32'hA800_0033);

    // Vector table walk: R5 R6 R7 R8
    pre = cur_status;
    for (int i = 0; i < 10; i++) begin
      k  = VEC[i][8:6];
      hv = VEC[i][5];
      m  = VEC[i][4:0];
      f  = (k == 3'd0) || (k == 3'd7);
      ra = 32'h0000_2000 + 32'(i) * 4;
      exp_pc = (hv ? 32'hFFFF_0000 : 32'd0) + {27'd0, k, 2'b00};
      exp_sr = {pre[31:8], 1'b1, f | pre[6], 1'b0, m};

      exc_req = 1'b1; exc_kind = k; hivec_en = hv; exc_ret_addr = ra;
      tick();
      exc_req = 1'b0; hivec_en = 1'b0;
      chk("R6 entry mode", {27'd0, cur_mode}, {27'd0, m});
      chk("R5 entry status", cur_status, exp_sr);
      chk("R6 pc_load on entry", {31'd0, pc_load}, 32'd1);
      chk(hv ? "R7 high vector" : "R6 vector", pc_next, exp_pc);
      rreg(4'd14, v); chk("R6 link register", v, ra);

      exc_return = 1'b1;
      tick();
      exc_return = 1'b0;
      chk("R8 status restored", cur_status, pre);
      chk("R8 pc from link", pc_next, ra);
      chk("R8 pc_load on return", {31'd0, pc_load}, 32'd1);
    end
    tick();
    chk("R12 pc_load idle", {31'd0, pc_load}, 32'd0);

    // R11 user-mode protection
    srw(4'b0001, 32'h0000_0010);
    chk("R4 user mode", {27'd0, cur_mode}, 32'h10);
    wreg(4'd14, 32'h0000_7777);
    srw(4'b1111, 32'h55FF_FFDF);
    chk("R11 user only flags", cur_status, 32'h5500_0010);

    // R9 return from user
    exc_return = 1'b1;
    tick();
    exc_return = 1'b0;
    chk("R9 status unchanged", cur_status, 32'h5500_0010);
    chk("R9 pc from user r14", pc_next, 32'h0000_7777);

    // R12 precedence
    exc_req = 1'b1; exc_kind = 3'd2; exc_ret_addr = 32'h0000_3000;
    exc_return = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0BAD;
    sr_wr_en = 1'b1; sr_wr_mask = 4'hF; sr_wr_data = 32'h0;
    tick();
    exc_req = 1'b0; exc_return = 1'b0; wr_en = 1'b0; sr_wr_en = 1'b0;
    chk("R12 entry wins", cur_status, 32'h5500_0093);
    chk("R12 vector", pc_next, 32'h0000_0008);
    rreg(4'd0, v);  chk("R12 write cancelled", v, 32'h1111_0000);
    rreg(4'd14, v); chk("R12 SVC link", v, 32'h0000_3000);
    exc_return = 1'b1;
    tick();
    exc_return = 1'b0;
    chk("R8 back to user", cur_status, 32'h5500_0010);

    // R1 reset again mid-run
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    chk("R1 status after reset", cur_status, 32'h0000_00D3);
    rreg(4'd0, v); chk("R1 r0 cleared", v, 32'd0);

    finish_run();
  end
endmodule